// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Controller

This block holds the digital state behind four 16-bit digital-to-analog converter channels. It receives already-deserialized 32-bit command words from a serial front end, along with a marker that shows when a word is being shifted in and a strobe for the completed word. Each channel has two register ranks. The staging rank is written by commands. The output rank drives the converter code. A per-channel override mask chooses whether a channel's output rank follows every write at once or waits for the external load pin.

Two asynchronous pins are brought into the system clock domain: an active-low load pin and an active-low clear pin. The falling edge of the clear pin forces both ranks of every channel to a programmable clear value. While the clear pin is low, the load pin has no effect. A clear edge that arrives while a word is being shifted in cancels that word. Each channel also carries a 2-bit power state. A static power-on select input decides whether reset yields zero or midscale.

Command word fields used by the block:

- Opcode: bits 27..24.
- Address: bits 23..20.
- Code: bits 19..4.
- Power state: bits 9..8.
- Channel mask or clear selector: the low bits.

Top module: `qdac_reg_ctrl`

## Requirements
- R1: While `rst` is high, every staging and output register loads 0x0000 if `por_mid` is 0, or 0x8000 if `por_mid` is 1. The override mask and the clear selector reset to 0, and every power state resets to 00 (normal).
- R2: Opcode 0000 writes the code field into the staging register of the addressed channel. The output register of a channel with mask bit 0 does not change while the load pin is high.
- R3: Opcode 0001 copies the addressed channel's staging register into its output register.
- R4: Opcode 0010 writes the addressed staging register. In the same cycle, every channel copies its staging register (including the new value) into its output register.
- R5: Opcode 0011 writes both the staging and the output register of the addressed channel.
- R6: Address 0000..0011 selects channel 0..3, address 1111 selects all channels, and any other address selects none.
- R7: While the synchronized load pin is low and the synchronized clear pin is high, every channel with mask bit 0 copies its staging register into its output register, including a value written in that same cycle. A pin level change takes effect in the third clock edge after it is applied.
- R8: Opcode 0110 loads the override mask from bits 3..0. A channel with mask bit 1 updates its output register on every write to its staging register, whatever the load pin does.
- R9: Opcode 0101 loads the clear selector from bits 1..0. A falling edge of the synchronized clear pin sets both ranks of all channels as follows: selector 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, and 11 changes nothing.
- R10: While the synchronized clear pin is low, the load pin has no effect on any output register.
- R11: A word whose shift-in period (`frm_active` high) sees a clear falling edge, up to and including its strobe cycle, is discarded.
- R12: Opcode 0100 sets the power state to bits 9..8 for every channel whose bit in 3..0 is 1. The power states are 00 normal, 01 1 kOhm to ground, 10 100 kOhm to ground, and 11 high impedance. The address field is ignored and the code registers are kept.
- R13: Opcode 0111 applies the reset of R1 using the current `por_mid`.
- R14: Opcodes 1000..1111 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_mid | input | 1 | Reset value select: 0 zero, 1 midscale |
| load_n | input | 1 | Asynchronous active-low load pin |
| clear_n | input | 1 | Asynchronous active-low clear pin |
| frm_active | input | 1 | High while a command word is being shifted in |
| frm_done | input | 1 | One-cycle strobe: `frm_word` is complete |
| frm_word | input | 32 | Completed command word |
| dac_code | output | 64 | Output-rank codes, channel i at bits 16i+15..16i |
| pwr_mode | output | 8 | Power state, channel i at bits 2i+1..2i |

## Verification
The bench builds the block with four channels and a two-stage synchronizer. With four channels, every channel address and the broadcast address are decoded, so masks, power-state channel bits and partial address selection can all differ per channel. With two synchronizer stages, a pin event takes effect three edges after it is applied, so the bench can place a clear edge inside a single word and hold a load pulse within a clear-low window, both within a few cycles.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CODE_W   = 16;
    localparam int WORD_W   = 32;
    localparam int SEL_W    = 4;
    localparam int OP_LSB   = 24;
    localparam int ADDR_LSB = 20;
    localparam int CODE_LSB = 4;
    localparam int PWR_LSB  = 8;
    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef enum logic [3:0] {
        OP_WR_IN   = 4'h0,
        OP_UPD     = 4'h1,
        OP_WR_ALL  = 4'h2,
        OP_WR_UPD  = 4'h3,
        OP_PWR     = 4'h4,
        OP_CLRSEL  = 4'h5,
        OP_MASK    = 4'h6,
        OP_RESET   = 4'h7
    } op_e;

    typedef enum logic [1:0] {
        PWR_ON   = 2'b00,
        PWR_1K   = 2'b01,
        PWR_100K = 2'b10,
        PWR_HIZ  = 2'b11
    } pwr_e;

    typedef struct packed {
        logic              op_ok;
        op_e               op;
        logic [3:0]        addr;
        logic [CODE_W-1:0] code;
        pwr_e              pwr;
        logic [SEL_W-1:0]  chsel;
        logic [1:0]        csel;
    } frame_t;

    function automatic logic [CODE_W-1:0] clear_value(input logic [1:0] sel);
        case (sel)
            2'b00:   clear_value = '0;
            2'b01:   clear_value = {1'b1, {(CODE_W-1){1'b0}}};
            default: clear_value = '1;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] por_value(input logic mid);
        por_value = mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    endfunction

endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin,
    output logic lvl,
    output logic fell
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // The chain keeps sampling during reset, so an edge that occurs while
    // reset is applied has already passed when reset is released.
    always_ff @(posedge clk) begin
        sh_q   <= {sh_q[STAGES-2:0], pin};
        prev_q <= sh_q[STAGES-1];
    end

    assign lvl  = sh_q[STAGES-1];
    assign fell = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/qdac_frame_decode.sv
module qdac_frame_decode
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [WORD_W-1:0] word,
    output frame_t            fr,
    output logic [NUM_CH-1:0] hit
);
    logic unused_hi;
    assign unused_hi = ^word[WORD_W-1:OP_LSB+4];

    always_comb begin
        fr.op_ok = ~word[OP_LSB+3];
        fr.op    = op_e'({1'b0, word[OP_LSB+2:OP_LSB]});
        fr.addr  = word[ADDR_LSB +: 4];
        fr.code  = word[CODE_LSB +: CODE_W];
        fr.pwr   = pwr_e'(word[PWR_LSB +: 2]);
        fr.chsel = word[0 +: SEL_W];
        fr.csel  = word[1:0];
    end

    // R6: per-channel address match plus broadcast
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
            assign hit[i] = (fr.addr == 4'(i)) || (fr.addr == ADDR_ALL);
        end
    endgenerate
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_all,
    input  logic [CODE_W-1:0]        rst_code,
    input  logic                     clr_go,
    input  logic [CODE_W-1:0]        clr_code,
    input  logic [NUM_CH-1:0]        wr_in,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic [NUM_CH-1:0]        upd,
    input  logic [NUM_CH-1:0]        pwr_wr,
    input  pwr_e                     pwr_val,
    output logic [NUM_CH*CODE_W-1:0] dac_flat,
    output logic [NUM_CH*2-1:0]      pwr_flat
);
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic [CODE_W-1:0] inp_q, dac_q, inp_nx;
            pwr_e              pwr_q;

            assign inp_nx = wr_in[i] ? wr_code : inp_q;

            always_ff @(posedge clk) begin
                if (rst_all) begin
                    inp_q <= rst_code;
                    dac_q <= rst_code;
                    pwr_q <= PWR_ON;
                end else if (clr_go) begin
                    inp_q <= clr_code;
                    dac_q <= clr_code;
                end else begin
                    inp_q <= inp_nx;
                    if (upd[i])    dac_q <= inp_nx;
                    if (pwr_wr[i]) pwr_q <= pwr_val;
                end
            end

            assign dac_flat[i*CODE_W +: CODE_W] = dac_q;
            assign pwr_flat[i*2 +: 2]           = pwr_q;
        end
    endgenerate
endmodule

// File: rtl/qdac_reg_ctrl.sv
module qdac_reg_ctrl
    import qdac_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     por_mid,
    input  logic                     load_n,
    input  logic                     clear_n,
    input  logic                     frm_active,
    input  logic                     frm_done,
    input  logic [WORD_W-1:0]        frm_word,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH*2-1:0]      pwr_mode
);
    logic ld_lvl, unused_ld_fell, clr_lvl, clr_fell;

    qdac_pin_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
        .clk(clk), .pin(load_n), .lvl(ld_lvl), .fell(unused_ld_fell));
    qdac_pin_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk(clk), .pin(clear_n), .lvl(clr_lvl), .fell(clr_fell));

    frame_t            fr;
    logic [NUM_CH-1:0] hit;

    qdac_frame_decode #(.NUM_CH(NUM_CH)) u_dec (
        .word(frm_word), .fr(fr), .hit(hit));

    logic              abort_q;
    logic [NUM_CH-1:0] mask_q;
    logic [1:0]        csel_q;
    logic              take, is_write, sw_rst, rst_all, clr_go, load_open;
    logic [NUM_CH-1:0] wr_in, upd, pwr_wr;

    // R11: a clear edge inside a word, or on its strobe, drops the word
    assign take      = frm_done & ~abort_q & ~clr_fell;
    assign is_write  = fr.op_ok & (fr.op == OP_WR_IN || fr.op == OP_WR_ALL ||
                                   fr.op == OP_WR_UPD);
    // R13: software reset shares the reset path
    assign sw_rst    = take & fr.op_ok & (fr.op == OP_RESET);
    assign rst_all   = rst | sw_rst;
    // R9: selector 11 leaves the registers alone
    assign clr_go    = clr_fell & (csel_q != 2'b11);
    // R10: load pin is gated by the clear level
    assign load_open = ~ld_lvl & clr_lvl;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ctl
            assign wr_in[i]  = take & is_write & hit[i];
            // R3 R4 R5 R7 R8
            assign upd[i]    = (take & fr.op_ok & (fr.op == OP_UPD) & hit[i])
                             | (take & fr.op_ok & (fr.op == OP_WR_ALL))
                             | (wr_in[i] & ((fr.op == OP_WR_UPD) | mask_q[i]))
                             | (~mask_q[i] & load_open);
            // R12: channel bits, address ignored
            assign pwr_wr[i] = take & fr.op_ok & (fr.op == OP_PWR) & fr.chsel[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) abort_q <= 1'b0;
        else     abort_q <= frm_active & (abort_q | clr_fell);
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            mask_q <= '0;
            csel_q <= 2'b00;
        end else if (take && fr.op_ok) begin
            if (fr.op == OP_MASK)   mask_q <= fr.chsel[NUM_CH-1:0];
            if (fr.op == OP_CLRSEL) csel_q <= fr.csel;
        end
    end

    qdac_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk     (clk),
        .rst_all (rst_all),
        .rst_code(por_value(por_mid)),
        .clr_go  (clr_go),
        .clr_code(clear_value(csel_q)),
        .wr_in   (wr_in),
        .wr_code (fr.code),
        .upd     (upd),
        .pwr_wr  (pwr_wr),
        .pwr_val (fr.pwr),
        .dac_flat(dac_code),
        .pwr_flat(pwr_mode)
    );
endmodule

// File: rtl/qdac_reg_ctrl_chk.sv
module qdac_reg_ctrl_chk
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     clr_lvl,
    input logic                     clr_fell,
    input logic                     take,
    input logic                     abort_q,
    input logic                     frm_done,
    input logic [1:0]               csel_q,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH*2-1:0]      pwr_mode
);
    // R10
    clear_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_lvl && !clr_fell && !take) |=> $stable(dac_code));

    // R9
    clear_value_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_fell && csel_q != 2'b11) |=>
            (dac_code == {NUM_CH{clear_value($past(csel_q))}}));

    // R11
    frame_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_done && (abort_q || clr_fell)) |=> $stable(pwr_mode));

    // R12
    pwr_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pwr_mode) |-> ($past(frm_done) || $past(rst)));
endmodule

bind qdac_reg_ctrl qdac_reg_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .clr_lvl (clr_lvl),
    .clr_fell(clr_fell),
    .take    (take),
    .abort_q (abort_q),
    .frm_done(frm_done),
    .csel_q  (csel_q),
    .dac_code(dac_code),
    .pwr_mode(pwr_mode)
);

// File: tb/qdac_reg_ctrl_tb_top.sv
module qdac_reg_ctrl_tb_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1, por_mid = 1'b0, load_n = 1'b1, clear_n = 1'b1;
    logic        frm_active = 1'b0, frm_done = 1'b0;
    logic [31:0] frm_word = '0;
    logic [NCH*16-1:0] dac_code;
    logic [NCH*2-1:0]  pwr_mode;

    qdac_reg_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .por_mid(por_mid), .load_n(load_n),
        .clear_n(clear_n), .frm_active(frm_active), .frm_done(frm_done),
        .frm_word(frm_word), .dac_code(dac_code), .pwr_mode(pwr_mode));

    int    checks = 0, errs = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // ---------------- behavioural reference ----------------
    int m_inp[NCH], m_dac[NCH], m_pwr[NCH];
    int m_mask = 0, m_csel = 0;
    bit m_abort = 0;
    bit ld1 = 1, ld2 = 1, cl1 = 1, cl2 = 1, clp = 1;

    function automatic int clr_val(int s);
        return (s == 0) ? 0 : (s == 1) ? 32768 : 65535;
    endfunction

    always @(posedge clk) begin : model
        bit cfall, lopen, tk;
        int op, ad, cd;
        cfall = clp && !cl2;
        lopen = !ld2 && cl2;
        op = int'(frm_word[27:24]);
        ad = int'(frm_word[23:20]);
        cd = int'(frm_word[19:4]);
        tk = frm_done && !m_abort && !cfall;
        if (rst || (tk && op == 7)) begin
            for (int c = 0; c < NCH; c++) begin
                m_inp[c] = por_mid ? 32768 : 0;
                m_dac[c] = m_inp[c];
                m_pwr[c] = 0;
            end
            m_mask = 0;
            m_csel = 0;
        end else if (cfall) begin
            if (m_csel != 3)
                for (int c = 0; c < NCH; c++) begin
                    m_inp[c] = clr_val(m_csel);
                    m_dac[c] = m_inp[c];
                end
        end else begin
            if (tk) begin
                for (int c = 0; c < NCH; c++) begin
                    bit h;
                    h = (ad == c) || (ad == 15);
                    if (h && (op == 0 || op == 2 || op == 3)) begin
                        m_inp[c] = cd;
                        if (op == 3 || m_mask[c]) m_dac[c] = cd;
                    end
                    if (h && op == 1) m_dac[c] = m_inp[c];
                    if (op == 4 && frm_word[c]) m_pwr[c] = int'(frm_word[9:8]);
                end
                if (op == 2)
                    for (int c = 0; c < NCH; c++) m_dac[c] = m_inp[c];
                if (op == 5) m_csel = int'(frm_word[1:0]);
                if (op == 6) m_mask = int'(frm_word[3:0]);
            end
            for (int c = 0; c < NCH; c++)
                if (!m_mask[c] && lopen) m_dac[c] = m_inp[c];
        end
        m_abort = rst ? 1'b0 : (frm_active && (m_abort || cfall));
        clp = cl2; cl2 = cl1; cl1 = clear_n;
        ld2 = ld1; ld1 = load_n;
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (int'(dac_code[c*16 +: 16]) != m_dac[c]) begin
                    errs++;
                    $display("FAIL %s: ch%0d code actual=%h expected=%h",
                             cur_req, c, dac_code[c*16 +: 16], m_dac[c][15:0]);
                end
                checks++;
                if (int'(pwr_mode[c*2 +: 2]) != m_pwr[c]) begin
                    errs++;
                    $display("FAIL %s: ch%0d power actual=%0d expected=%0d",
                             cur_req, c, pwr_mode[c*2 +: 2], m_pwr[c]);
                end
            end
        end
    end

    // Fixed-value spot check, independent of the model
    task automatic expect_code(input int ch, input logic [15:0] val, input string tag);
        checks++;
        if (dac_code[ch*16 +: 16] !== val) begin
            errs++;
            $display("FAIL %s: ch%0d actual=%h expected=%h", tag, ch,
                     dac_code[ch*16 +: 16], val);
        end
    endtask

    task automatic expect_pwr(input int ch, input logic [1:0] val, input string tag);
        checks++;
        if (pwr_mode[ch*2 +: 2] !== val) begin
            errs++;
            $display("FAIL %s: ch%0d power actual=%0d expected=%0d", tag, ch,
                     pwr_mode[ch*2 +: 2], val);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] ad, input logic [19:0] low);
        @(negedge clk) frm_active = 1'b1;
        idle(2);
        frm_done = 1'b1;
        frm_word = {4'h0, op, ad, low};
        @(negedge clk);
        frm_done = 1'b0;
        frm_active = 1'b0;
        frm_word = '0;
    endtask

    task automatic wcode(input logic [3:0] op, input logic [3:0] ad, input logic [15:0] cd);
        send(op, ad, {cd, 4'h0});
    endtask

    task automatic pulse_load;
        @(negedge clk) load_n = 1'b0;
        idle(3);
        load_n = 1'b1;
        idle(4);
    endtask

    task automatic pulse_clear;
        @(negedge clk) clear_n = 1'b0;
        idle(4);
        clear_n = 1'b1;
        idle(4);
    endtask

    task automatic finish_run;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        idle(4);
        rst = 1'b0;
        idle(1);
        cur_req = "R1";
        for (int c = 0; c < NCH; c++) begin
            expect_code(c, 16'h0000, "R1");
            expect_pwr(c, 2'b00, "R1");
        end

        cur_req = "R2";
        wcode(4'h0, 4'h0, 16'h1234);
        idle(2);
        expect_code(0, 16'h0000, "R2");

        cur_req = "R3";
        wcode(4'h1, 4'h0, 16'h0000);
        expect_code(0, 16'h1234, "R3");

        cur_req = "R6";
        wcode(4'h3, 4'h5, 16'hDEAD);
        wcode(4'h0, 4'hF, 16'hAAAA);
        wcode(4'h1, 4'hF, 16'h0000);
        for (int c = 0; c < NCH; c++) expect_code(c, 16'hAAAA, "R6");

        cur_req = "R5";
        wcode(4'h3, 4'h2, 16'h5555);
        expect_code(2, 16'h5555, "R5");
        expect_code(1, 16'hAAAA, "R5");

        cur_req = "R4";
        wcode(4'h0, 4'h1, 16'h1111);
        wcode(4'h2, 4'h3, 16'h3333);
        expect_code(1, 16'h1111, "R4");
        expect_code(3, 16'h3333, "R4");

        cur_req = "R7";
        wcode(4'h0, 4'h0, 16'h7777);
        expect_code(0, 16'hAAAA, "R7");
        pulse_load();
        expect_code(0, 16'h7777, "R7");
        @(negedge clk) load_n = 1'b0;
        idle(4);
        wcode(4'h0, 4'h1, 16'h0101);
        expect_code(1, 16'h0101, "R7");
        load_n = 1'b1;
        idle(4);

        cur_req = "R8";
        send(4'h6, 4'h0, 20'h00004);
        wcode(4'h0, 4'h2, 16'h2222);
        expect_code(2, 16'h2222, "R8");
        wcode(4'h0, 4'h0, 16'h0F0F);
        expect_code(0, 16'h7777, "R8");
        pulse_load();
        expect_code(0, 16'h0F0F, "R8");
        send(4'h6, 4'h0, 20'h00000);

        cur_req = "R9";
        send(4'h5, 4'h0, 20'h00001);
        pulse_clear();
        for (int c = 0; c < NCH; c++) expect_code(c, 16'h8000, "R9");
        send(4'h5, 4'h0, 20'h00002);
        pulse_clear();
        for (int c = 0; c < NCH; c++) expect_code(c, 16'hFFFF, "R9");
        wcode(4'h3, 4'h1, 16'h0042);
        send(4'h5, 4'h0, 20'h00003);
        pulse_clear();
        expect_code(1, 16'h0042, "R9");
        send(4'h5, 4'h0, 20'h00000);

        cur_req = "R10";
        @(negedge clk) clear_n = 1'b0;
        idle(4);
        expect_code(1, 16'h0000, "R10");
        wcode(4'h0, 4'h0, 16'h4444);
        pulse_load();
        expect_code(0, 16'h0000, "R10");
        clear_n = 1'b1;
        idle(4);
        pulse_load();
        expect_code(0, 16'h4444, "R10");

        cur_req = "R11";
        send(4'h5, 4'h0, 20'h00002);
        @(negedge clk) begin frm_active = 1'b1; clear_n = 1'b0; end
        idle(5);
        frm_done = 1'b1;
        frm_word = {4'h0, 4'h3, 4'h1, 16'h9999, 4'h0};
        @(negedge clk);
        frm_done = 1'b0;
        frm_active = 1'b0;
        frm_word = '0;
        idle(2);
        expect_code(1, 16'hFFFF, "R11");
        clear_n = 1'b1;
        idle(4);

        cur_req = "R12";
        wcode(4'h3, 4'h0, 16'h1357);
        send(4'h4, 4'h2, 20'h00205);
        expect_pwr(0, 2'b10, "R12");
        expect_pwr(1, 2'b00, "R12");
        expect_pwr(2, 2'b10, "R12");
        send(4'h4, 4'h0, 20'h00302);
        expect_pwr(1, 2'b11, "R12");
        expect_code(0, 16'h1357, "R12");
        send(4'h4, 4'h0, 20'h0010F);
        for (int c = 0; c < NCH; c++) expect_pwr(c, 2'b01, "R12");
        send(4'h4, 4'h0, 20'h0000F);

        cur_req = "R14";
        for (int k = 8; k < 16; k++) send(4'(k), 4'hF, 20'hFFFFF);
        expect_code(0, 16'h1357, "R14");
        for (int c = 0; c < NCH; c++) expect_pwr(c, 2'b00, "R14");

        cur_req = "R13";
        send(4'h6, 4'h0, 20'h0000F);
        por_mid = 1'b1;
        send(4'h7, 4'h0, 20'h00000);
        for (int c = 0; c < NCH; c++) expect_code(c, 16'h8000, "R13");
        wcode(4'h0, 4'h3, 16'h0BAD);
        expect_code(3, 16'h8000, "R13");

        cur_req = "R1";
        @(negedge clk) rst = 1'b1;
        idle(4);
        rst = 1'b0;
        idle(1);
        for (int c = 0; c < NCH; c++) expect_code(c, 16'h8000, "R1");
        idle(3);
        finish_run();
    end
endmodule